// File: doc/BRIEF.md
# Key Provisioning and Lock Sequencer

This block stands between a controller and a bank of one-time-programmable key slots. It accepts one command per cycle: burn a key into a slot under a purpose code, burn a 512-bit key across two neighbouring slots, step or finalise the flash-encryption counter, enable secure boot, or write-lock an empty slot. Read and write protection follow from the purpose code, so the caller never sets protection bits directly. Reset stands in for a fresh, unprogrammed bank.

Every command gets a one-cycle completion pulse with a 3-bit status code in the cycle after it is issued. Refused commands leave all state untouched. A read port returns a slot's key (forced to zero when the slot is read-disabled) and its purpose code. Once secure boot is on, the read-disable bits are frozen, so any later burn that would need read protection is refused with an ordering error. A single flag reports when the configuration is secure.

Top module: `key_prov_seq`

## Requirements
- R1: After reset all slots are unused, unlocked and readable with key and purpose zero, the counter is 000 and unlocked, secure boot is off, done_o is 0, status_o is 0 and secure_o is 0.
- R2: Burning with purpose HMAC (1) or XTS-128 (2) stores the key and sets the slot's read-disable and write-disable bits; the read port then returns zero key data for that slot.
- R3: Burning with a signature-digest purpose (5, 6 or 7) sets write-disable but not read-disable; the read port returns the burned key.
- R4: Burning with purpose USER (0) sets neither protection bit but marks the slot used; the purpose is read back on rd_purpose_o, and a later burn to a used slot returns status 1 (slot in use).
- R5: Status 3 (invalid) is returned, with no state change, for a slot index at or above NUM_SLOTS, a purpose above 7, purpose 3 or 4 in a single-slot burn, purpose 2 on the last slot, a wide burn whose second slot is the last slot or beyond, and opcodes 6 and 7.
- R6: A wide burn (opcode 1) at slot s writes key_lo_i to s with purpose 3 and key_hi_i to s+1 with purpose 4, both read- and write-disabled; it is refused unless both slots are free.
- R7: Opcode 5 write-locks a slot; a burn touching a write-disabled slot returns status 2 (locked), which takes priority over status 1.
- R8: Opcode 2 steps the counter 000, 001, 011, 111; fe_on_o is the counter's odd parity. Stepping needs a burned XTS key (purpose 2, 3 or 4) else status 4, and at 111 or when locked returns status 2.
- R9: Opcode 3 sets the counter to 111 and locks it (fe_lock_o); afterwards opcodes 2 and 3 return status 2 and the counter never changes. It needs an XTS key, else status 4.
- R10: Opcode 4 enables secure boot only if a digest key is burned (else status 4); from then on the read-disable bits never change and a burn with purpose 1 to 4 or a wide burn returns status 4, while USER and digest burns still succeed.
- R11: secure_o is 1 exactly when the counter has odd popcount, secure boot is on, and every burned slot with purpose 1 to 4 is read-disabled.
- R12: done_o is high for exactly the cycle after each cycle with cmd_valid_i high, with status_o giving that command's result (0 OK, 1 in use, 2 locked, 3 invalid, 4 ordering error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command issued this cycle |
| cmd_op_i | input | 3 | Opcode: 0 burn, 1 wide burn, 2 counter step, 3 counter finalise, 4 secure-boot enable, 5 slot lock |
| cmd_slot_i | input | SLOT_W | Target slot |
| cmd_purpose_i | input | 4 | Purpose code for a single burn |
| key_lo_i | input | KEY_W | Key data (first half for a wide burn) |
| key_hi_i | input | KEY_W | Second half for a wide burn |
| rd_slot_i | input | SLOT_W | Slot selected on the read port |
| rd_key_o | output | KEY_W | Key of the selected slot, zero if read-disabled |
| rd_purpose_o | output | 4 | Purpose of the selected slot |
| done_o | output | 1 | Completion pulse |
| status_o | output | 3 | Result of the completed command |
| used_o | output | NUM_SLOTS | Per-slot burned flag |
| rd_dis_o | output | NUM_SLOTS | Per-slot read-disable |
| wr_dis_o | output | NUM_SLOTS | Per-slot write-disable |
| fe_cnt_o | output | 3 | Flash-encryption counter |
| fe_on_o | output | 1 | Flash encryption enabled (odd popcount) |
| fe_lock_o | output | 1 | Counter write-locked |
| sb_en_o | output | 1 | Secure boot enabled |
| secure_o | output | 1 | Configuration is secure |

## Verification
The assertions take for granted that commands arrive at most one per cycle as single-cycle strobes, with opcode, slot, purpose and key stable in the cycle cmd_valid_i is high; they place no limit on slot, purpose or opcode values, since out-of-range codes must be refused. The random stimulus issues one command, waits for its pulse and checks the whole state, so the strobe rule always holds, and it deliberately spreads slot indices and purpose codes past their legal ranges. Bank contents are cleared by a reset every few dozen commands so that free slots keep reappearing and the ordering rules between secure boot, encryption and key burns are reached from many histories.

// File: rtl/key_prov_seq.sv
module key_prov_seq #(
  parameter int NUM_SLOTS = 6,
  parameter int KEY_W     = 256,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic [SLOT_W-1:0]    cmd_slot_i,
  input  logic [3:0]           cmd_purpose_i,
  input  logic [KEY_W-1:0]     key_lo_i,
  input  logic [KEY_W-1:0]     key_hi_i,
  input  logic [SLOT_W-1:0]    rd_slot_i,
  output logic [KEY_W-1:0]     rd_key_o,
  output logic [3:0]           rd_purpose_o,
  output logic                 done_o,
  output logic [2:0]           status_o,
  output logic [NUM_SLOTS-1:0] used_o,
  output logic [NUM_SLOTS-1:0] rd_dis_o,
  output logic [NUM_SLOTS-1:0] wr_dis_o,
  output logic [2:0]           fe_cnt_o,
  output logic                 fe_on_o,
  output logic                 fe_lock_o,
  output logic                 sb_en_o,
  output logic                 secure_o
);

  localparam logic [2:0] OP_BURN = 3'd0, OP_WIDE = 3'd1, OP_STEP = 3'd2,
                         OP_FINAL = 3'd3, OP_SBOOT = 3'd4, OP_LOCK = 3'd5;
  localparam logic [2:0] ST_OK = 3'd0, ST_USED = 3'd1, ST_LOCKED = 3'd2,
                         ST_INVALID = 3'd3, ST_ORDER = 3'd4;
  localparam logic [3:0] P_USER = 4'd0, P_XTS128 = 4'd2, P_WIDE_A = 4'd3,
                         P_WIDE_B = 4'd4;

  function automatic logic needs_rd(input logic [3:0] p);
    return (p >= 4'd1) && (p <= 4'd4);
  endfunction
  function automatic logic is_xts(input logic [3:0] p);
    return (p >= 4'd2) && (p <= 4'd4);
  endfunction
  function automatic logic is_digest(input logic [3:0] p);
    return (p >= 4'd5) && (p <= 4'd7);
  endfunction

  logic [NUM_SLOTS-1:0][KEY_W-1:0] key_q;
  logic [NUM_SLOTS-1:0][3:0]       purp_q;
  logic [NUM_SLOTS-1:0]            used_q, rd_dis_q, wr_dis_q;
  logic [2:0]                      cnt_q;
  logic                            cnt_lock_q, sb_q, done_q;
  logic [2:0]                      status_q;

  logic [NUM_SLOTS-1:0] sel_a, sel_b, tgt, sens_m, xts_m, dig_m;
  logic                 wide, slot_ok, bad, have_xts, have_dig, prot_ok, need_prot;
  logic [2:0]           st;

  always_comb begin
    sel_a  = '0;
    sens_m = '0;
    xts_m  = '0;
    dig_m  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (cmd_slot_i == SLOT_W'(i)) sel_a[i] = 1'b1;
      sens_m[i] = used_q[i] & needs_rd(purp_q[i]);
      xts_m[i]  = used_q[i] & is_xts(purp_q[i]);
      dig_m[i]  = used_q[i] & is_digest(purp_q[i]);
    end
  end

  assign sel_b     = sel_a << 1;
  assign wide      = (cmd_op_i == OP_WIDE);
  assign tgt       = wide ? (sel_a | sel_b) : sel_a;
  assign slot_ok   = |sel_a;
  assign have_xts  = |xts_m;
  assign have_dig  = |dig_m;
  assign prot_ok   = &(~sens_m | rd_dis_q);
  assign need_prot = wide | needs_rd(cmd_purpose_i);

  assign bad = !slot_ok
             || (!wide && (cmd_purpose_i > 4'd7 || cmd_purpose_i == P_WIDE_A ||
                           cmd_purpose_i == P_WIDE_B ||
                           (cmd_purpose_i == P_XTS128 && sel_a[NUM_SLOTS-1])))
             || (wide && (sel_b == '0 || sel_b[NUM_SLOTS-1]));

  always_comb begin
    case (cmd_op_i)
      OP_BURN, OP_WIDE: begin
        if (bad)                     st = ST_INVALID;
        else if (|(tgt & wr_dis_q))  st = ST_LOCKED;
        else if (|(tgt & used_q))    st = ST_USED;
        else if (need_prot && sb_q)  st = ST_ORDER;
        else                         st = ST_OK;
      end
      OP_STEP: begin
        if (cnt_lock_q || cnt_q == 3'b111) st = ST_LOCKED;
        else if (!have_xts)                st = ST_ORDER;
        else                               st = ST_OK;
      end
      OP_FINAL: begin
        if (cnt_lock_q)     st = ST_LOCKED;
        else if (!have_xts) st = ST_ORDER;
        else                st = ST_OK;
      end
      OP_SBOOT: st = (sb_q || have_dig) ? ST_OK : ST_ORDER;
      OP_LOCK:  st = slot_ok ? ST_OK : ST_INVALID;
      default:  st = ST_INVALID;
    endcase
  end

  wire apply = cmd_valid_i && (st == ST_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q      <= '0;
      purp_q     <= '0;
      used_q     <= '0;
      rd_dis_q   <= '0;
      wr_dis_q   <= '0;
      cnt_q      <= '0;
      cnt_lock_q <= 1'b0;
      sb_q       <= 1'b0;
      done_q     <= 1'b0;
      status_q   <= ST_OK;
    end else begin
      done_q <= cmd_valid_i;
      if (cmd_valid_i) status_q <= st;
      if (apply) begin
        case (cmd_op_i)
          OP_BURN: begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
              if (sel_a[i]) begin
                key_q[i]    <= key_lo_i;
                purp_q[i]   <= cmd_purpose_i;
                used_q[i]   <= 1'b1;
                rd_dis_q[i] <= needs_rd(cmd_purpose_i);
                wr_dis_q[i] <= (cmd_purpose_i != P_USER);
              end
            end
          end
          OP_WIDE: begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
              if (sel_a[i] || sel_b[i]) begin
                key_q[i]    <= sel_a[i] ? key_lo_i : key_hi_i;
                purp_q[i]   <= sel_a[i] ? P_WIDE_A : P_WIDE_B;
                used_q[i]   <= 1'b1;
                rd_dis_q[i] <= 1'b1;
                wr_dis_q[i] <= 1'b1;
              end
            end
          end
          OP_STEP:  cnt_q <= {cnt_q[1:0], 1'b1};
          OP_FINAL: begin
            cnt_q      <= 3'b111;
            cnt_lock_q <= 1'b1;
          end
          OP_SBOOT: sb_q <= 1'b1;
          OP_LOCK:  wr_dis_q <= wr_dis_q | sel_a;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_key_o     = '0;
    rd_purpose_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_slot_i == SLOT_W'(i)) begin
        rd_key_o     = rd_dis_q[i] ? '0 : key_q[i];
        rd_purpose_o = purp_q[i];
      end
    end
  end

  assign done_o    = done_q;
  assign status_o  = status_q;
  assign used_o    = used_q;
  assign rd_dis_o  = rd_dis_q;
  assign wr_dis_o  = wr_dis_q;
  assign fe_cnt_o  = cnt_q;
  assign fe_on_o   = ^cnt_q;
  assign fe_lock_o = cnt_lock_q;
  assign sb_en_o   = sb_q;
  assign secure_o  = (^cnt_q) & sb_q & prot_ok;

  a_r10_rd_dis_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    sb_q |=> $stable(rd_dis_q));

  a_r10_order_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && sb_q && (cmd_op_i == OP_WIDE ||
     (cmd_op_i == OP_BURN && needs_rd(cmd_purpose_i)))) |=> (status_o != ST_OK));

  a_r8_cnt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q inside {3'b000, 3'b001, 3'b011, 3'b111});

  a_r9_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lock_q |=> (cnt_lock_q && $stable(cnt_q)));

  a_r7_wr_dis_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i |=> ((wr_dis_q & $past(wr_dis_q)) == $past(wr_dis_q)));

  a_r5_invalid_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && st == ST_INVALID) |=> ($stable(used_q) && $stable(wr_dis_q)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i |=> done_o);

  a_r12_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_i |=> !done_o);

endmodule

// File: tb/key_prov_seq_tb.sv
module key_prov_seq_tb;
  localparam int NS = 6;
  localparam int KW = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [2:0] cmd_slot_i = '0;
  logic [3:0] cmd_purpose_i = '0;
  logic [KW-1:0] key_lo_i = '0, key_hi_i = '0;
  logic [2:0] rd_slot_i = '0;
  logic [KW-1:0] rd_key_o;
  logic [3:0] rd_purpose_o;
  logic done_o;
  logic [2:0] status_o;
  logic [NS-1:0] used_o, rd_dis_o, wr_dis_o;
  logic [2:0] fe_cnt_o;
  logic fe_on_o, fe_lock_o, sb_en_o, secure_o;

  always #5 clk = ~clk;

  key_prov_seq #(.NUM_SLOTS(NS), .KEY_W(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_slot_i(cmd_slot_i), .cmd_purpose_i(cmd_purpose_i), .key_lo_i(key_lo_i),
    .key_hi_i(key_hi_i), .rd_slot_i(rd_slot_i), .rd_key_o(rd_key_o),
    .rd_purpose_o(rd_purpose_o), .done_o(done_o), .status_o(status_o),
    .used_o(used_o), .rd_dis_o(rd_dis_o), .wr_dis_o(wr_dis_o), .fe_cnt_o(fe_cnt_o),
    .fe_on_o(fe_on_o), .fe_lock_o(fe_lock_o), .sb_en_o(sb_en_o), .secure_o(secure_o));

  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  logic [KW-1:0] m_key [NS];
  logic [3:0] m_purp [NS];
  bit m_used [NS], m_rd [NS], m_wr [NS];
  bit [2:0] m_cnt;
  bit m_lock, m_sb;

  task automatic chk(input bit ok, input string req, input logic [KW-1:0] act,
                     input logic [KW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit sens(input logic [3:0] p);
    return p >= 1 && p <= 4;
  endfunction

  function automatic bit any_purp(input int lo, input int hi);
    for (int i = 0; i < NS; i++)
      if (m_used[i] && m_purp[i] >= lo && m_purp[i] <= hi) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int model_status(input int op, input int s, input int p);
    bit w;
    w = (op == 1);
    case (op)
      0, 1: begin
        if (s >= NS) return 3;
        if (!w && (p > 7 || p == 3 || p == 4 || (p == 2 && s == NS - 1))) return 3;
        if (w && s + 1 >= NS - 1) return 3;
        if (m_wr[s] || (w && m_wr[s+1])) return 2;
        if (m_used[s] || (w && m_used[s+1])) return 1;
        if ((w || (p >= 1 && p <= 4)) && m_sb) return 4;
        return 0;
      end
      2: begin
        if (m_lock || m_cnt == 3'b111) return 2;
        if (!any_purp(2, 4)) return 4;
        return 0;
      end
      3: begin
        if (m_lock) return 2;
        if (!any_purp(2, 4)) return 4;
        return 0;
      end
      4: begin
        if (m_sb) return 0;
        if (!any_purp(5, 7)) return 4;
        return 0;
      end
      5: return (s >= NS) ? 3 : 0;
      default: return 3;
    endcase
  endfunction

  function automatic string stag(input int op, input int p, input int e);
    case (op)
      0, 1: begin
        if (e == 3) return "R5";
        if (e == 2) return "R7";
        if (e == 1) return "R4";
        if (e == 4) return "R10";
        if (op == 1) return "R6";
        if (p == 0) return "R4";
        return (p >= 5) ? "R3" : "R2";
      end
      2: return "R8";
      3: return "R9";
      4: return "R10";
      5: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic model_apply(input int op, input int s, input int p,
                             input logic [KW-1:0] lo, input logic [KW-1:0] hi);
    case (op)
      0: begin
        m_key[s] = lo; m_purp[s] = 4'(p); m_used[s] = 1;
        m_rd[s] = sens(4'(p)); m_wr[s] = (p != 0);
      end
      1: begin
        m_key[s] = lo; m_purp[s] = 4'd3; m_used[s] = 1; m_rd[s] = 1; m_wr[s] = 1;
        m_key[s+1] = hi; m_purp[s+1] = 4'd4; m_used[s+1] = 1; m_rd[s+1] = 1; m_wr[s+1] = 1;
      end
      2: m_cnt = {m_cnt[1:0], 1'b1};
      3: begin m_cnt = 3'b111; m_lock = 1; end
      4: m_sb = 1;
      5: m_wr[s] = 1;
      default: ;
    endcase
  endtask

  task automatic check_state();
    logic [NS-1:0] eu, er, ew;
    bit prot;
    prot = 1;
    for (int i = 0; i < NS; i++) begin
      eu[i] = m_used[i]; er[i] = m_rd[i]; ew[i] = m_wr[i];
      if (m_used[i] && sens(m_purp[i]) && !m_rd[i]) prot = 0;
    end
    chk(used_o == eu, "R4 used", KW'(used_o), KW'(eu));
    chk(rd_dis_o == er, "R2 rd_dis", KW'(rd_dis_o), KW'(er));
    chk(wr_dis_o == ew, "R3 wr_dis", KW'(wr_dis_o), KW'(ew));
    chk(fe_cnt_o == m_cnt, "R8 counter", KW'(fe_cnt_o), KW'(m_cnt));
    chk(fe_on_o == ^m_cnt, "R8 enabled", KW'(fe_on_o), KW'(^m_cnt));
    chk(fe_lock_o == m_lock, "R9 lock", KW'(fe_lock_o), KW'(m_lock));
    chk(sb_en_o == m_sb, "R10 secure boot", KW'(sb_en_o), KW'(m_sb));
    chk(secure_o == ((^m_cnt) & m_sb & prot), "R11 secure", KW'(secure_o),
        KW'((^m_cnt) & m_sb & prot));
    for (int s = 0; s < NS; s++) begin
      logic [KW-1:0] ek;
      rd_slot_i = 3'(s);
      #1;
      ek = m_rd[s] ? '0 : m_key[s];
      chk(rd_key_o == ek, m_rd[s] ? "R2 readback" : "R3 readback", rd_key_o, ek);
      chk(rd_purpose_o == m_purp[s], "R4 purpose", KW'(rd_purpose_o), KW'(m_purp[s]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid_i = 1'b0;
    for (int i = 0; i < NS; i++) begin
      m_key[i] = '0; m_purp[i] = '0; m_used[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
    end
    m_cnt = '0; m_lock = 0; m_sb = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 done", KW'(done_o), '0);
    chk(status_o == 3'd0, "R1 status", KW'(status_o), '0);
    check_state();
  endtask

  function automatic logic [KW-1:0] rkey();
    logic [KW-1:0] k;
    for (int i = 0; i < KW / 32; i++) k[i*32 +: 32] = $urandom;
    return k;
  endfunction

  task automatic do_cmd(input int op, input int s, input int p, output int got);
    int e;
    logic [KW-1:0] lo, hi;
    lo = rkey();
    hi = rkey();
    e = model_status(op, s, p);
    @(negedge clk);
    cmd_op_i = 3'(op); cmd_slot_i = 3'(s); cmd_purpose_i = 4'(p);
    key_lo_i = lo; key_hi_i = hi; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk(done_o == 1'b1, "R12 done", KW'(done_o), KW'(1));
    chk(status_o == 3'(e), stag(op, p, e), KW'(status_o), KW'(e));
    got = status_o;
    if (e == 0) model_apply(op, s, p, lo, hi);
    check_state();
    @(negedge clk);
    chk(done_o == 1'b0, "R12 pulse width", KW'(done_o), '0);
  endtask

  task automatic dcmd(input int op, input int s, input int p, input int want,
                      input string req);
    int got;
    do_cmd(op, s, p, got);
    chk(got == want, req, KW'(got), KW'(want));
  endtask

  initial begin
    void'($urandom(32'd20260311));
    do_reset();                    // R1
    dcmd(4, 0, 0, 4, "R10 no digest");
    dcmd(2, 0, 0, 4, "R8 no xts key");
    dcmd(0, 1, 1, 0, "R2 hmac burn");
    dcmd(0, 1, 1, 2, "R7 locked beats used");
    dcmd(0, 0, 0, 0, "R4 user burn");
    dcmd(0, 0, 7, 1, "R4 slot in use");
    dcmd(0, 5, 2, 3, "R5 xts on last slot");
    dcmd(0, 6, 0, 3, "R5 slot out of range");
    dcmd(0, 2, 3, 3, "R5 half purpose single");
    dcmd(0, 2, 9, 3, "R5 purpose code");
    dcmd(6, 0, 0, 3, "R5 opcode");
    dcmd(1, 4, 0, 3, "R5 wide into last slot");
    dcmd(1, 2, 0, 0, "R6 wide burn");
    dcmd(5, 5, 0, 0, "R7 lock slot");
    dcmd(0, 5, 5, 2, "R7 burn locked");
    dcmd(0, 4, 5, 0, "R3 digest burn");
    dcmd(2, 0, 0, 0, "R8 step 001");
    dcmd(2, 0, 0, 0, "R8 step 011");
    dcmd(2, 0, 0, 0, "R8 step 111");
    dcmd(2, 0, 0, 2, "R8 step at 111");
    dcmd(3, 0, 0, 0, "R9 finalise");
    dcmd(3, 0, 0, 2, "R9 finalise twice");
    dcmd(4, 0, 0, 0, "R11 secure boot on");

    do_reset();
    dcmd(0, 3, 6, 0, "R3 digest burn");
    dcmd(4, 0, 0, 0, "R10 secure boot on");
    dcmd(0, 0, 1, 4, "R10 hmac after sb");
    dcmd(1, 0, 0, 4, "R10 wide after sb");
    dcmd(0, 0, 0, 0, "R10 user after sb");
    dcmd(0, 2, 5, 0, "R10 digest after sb");
    dcmd(3, 0, 0, 4, "R9 no xts key");

    for (int ep = 0; ep < 60; ep++) begin
      do_reset();
      for (int n = 0; n < 30; n++) begin
        int r, op, s, p, got;
        r = $urandom % 16;
        if (r < 6) op = 0;
        else if (r < 8) op = 1;
        else if (r < 10) op = 2;
        else if (r < 11) op = 3;
        else if (r < 13) op = 4;
        else if (r < 14) op = 5;
        else op = 6 + (r - 14);
        s = $urandom % 8;
        p = ($urandom % 4 == 0) ? ($urandom % 16) : ($urandom % 8);
        do_cmd(op, s, p, got);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule